// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block drives serial NOR flash devices, one chip select each, on behalf of a memory-mapped byte window. Each chip select has its own 32-bit control word. The control word holds a transfer mode, a flash opcode, a dummy-byte count and a data lane width. A shared register holds one address-width flag per chip select. In read mode, a byte read on the window becomes a complete flash transaction: the opcode, then the address with its most significant byte first, then the dummy bytes, then one data byte collected over one, two or four lines.

In user mode, software frames the chip select by hand with a stop bit. Each byte written to the window is shifted out on one line. Each byte read from the window is clocked in from the flash at the configured lane width. The window uses a request/ready handshake. The host holds the request until a one-cycle ready pulse arrives, and the ready stays low for as long as the serial transfer takes.

The serial clock is the system clock divided by four, in SPI mode 0. The block changes output data while SCLK is low and samples input data on the rising SCLK edge.

Top module: `spi_seq`

## Requirements
- R1: Control bits [1:0] set the mode (0 normal, 1 read, 2 write, 3 user). A window read in read mode runs a flash transaction. In normal or write mode, any window access completes at once with read data 0 and no SCLK edge.
- R2: Control bit 2 is a stop bit and resets to 1. While it is set, that chip select's CS_n stays high. In user mode with the bit clear, CS_n stays low.
- R3: A read-mode transaction first sends the opcode from control bits [23:16], most significant bit first, on IO0.
- R4: The address follows the opcode, most significant byte first, on IO0. It is 3 bytes, or 4 bytes when bit n of the shared address-width register (cfg_sel 0) is set for chip select n. Control words sit at cfg_sel n+1.
- R5: After the address come N dummy bytes of 0xFF on IO0, where N = {ctrl[14], ctrl[7:6]} (0 to 7).
- R6: The data byte uses the lane width from control bits [30:28]: bit 30 selects quad, else bit 29 selects dual, else single. Single takes bit 7 first on IO1. Dual takes bits 7:6 on IO1:IO0 first. Quad takes bits 7:4 on IO3:IO0 first. All output enables are low during a dual or quad data phase.
- R7: SCLK idles low, and each bit time spans 4 clocks. Window ready stays low while a flash transfer runs and pulses high for exactly one cycle.
- R8: In user mode, a window write shifts the byte out on IO0, most significant bit first. A window read shifts one byte in at the configured lane width.
- R9: A window write in read mode is ignored: it completes at once with no SCLK edge and no CS_n activity.
- R10: After reset, every CS_n is high, SCLK is low, all output enables are low and ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | SEL_W | 0 = address-width register, n+1 = control word of chip select n |
| cfg_wdata | input | 32 | Register write data |
| win_req | input | 1 | Window access request, held until ready |
| win_we | input | 1 | 1 = window write, 0 = window read |
| win_cs | input | CS_W | Chip select targeted by the access |
| win_addr | input | WIN_AW | Flash byte address for read-mode transactions |
| win_wdata | input | 8 | Byte written in user mode |
| win_rdata | output | 8 | Byte returned by a window read |
| win_ready | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| io_out | output | 4 | Serial data outputs |
| io_oe | output | 4 | Output enables for io_out |
| io_in | input | 4 | Serial data inputs |

## Verification
The main read path is exercised with five transaction shapes. They cover 3- and 4-byte addressing, dummy counts of 0, 1, 4 and 5, and single, dual and quad data phases on both chip selects. A fault in the address-width flag, the split dummy field, the lane bit order or the chip-select routing therefore appears in a different check in each case. For each transaction, a behavioural flash records every bit on IO0 and counts the SCLK rising edges. This lets the checks separate a wrong opcode from a wrong address, a wrong dummy count or a bad data capture. User-mode byte writes and reads, and the stop-bit framing, are checked separately. So are the mode combinations that must finish without any serial activity.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_READ   = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_USER   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    LANE_X1 = 2'd0,
    LANE_X2 = 2'd1,
    LANE_X4 = 2'd2
  } lane_e;

  typedef struct packed {
    mode_e      mode;
    logic       stop;
    logic [7:0] opcode;
    lane_e      lanes;
    logic [2:0] dummy;
    logic       addr4;
  } cs_cfg_t;

  localparam int          STOP_BIT   = 2;
  localparam int          OPC_LSB    = 16;
  localparam int          DUM_HI_BIT = 14;
  localparam int          DUM_LO_LSB = 6;
  localparam int          DUAL_BIT   = 29;
  localparam int          QUAD_BIT   = 30;
  localparam logic [31:0] CTRL_RESET = 32'h0000_0004;

  function automatic cs_cfg_t decode_ctrl(input logic [31:0] w);
    cs_cfg_t c;
    c.mode   = mode_e'(w[1:0]);
    c.stop   = w[STOP_BIT];
    c.opcode = w[OPC_LSB +: 8];
    if (w[QUAD_BIT])      c.lanes = LANE_X4;
    else if (w[DUAL_BIT]) c.lanes = LANE_X2;
    else                  c.lanes = LANE_X1;
    c.dummy  = {w[DUM_HI_BIT], w[DUM_LO_LSB +: 2]};
    c.addr4  = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/spi_seq_regs.sv
module spi_seq_regs
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [SEL_W-1:0]       cfg_sel,
  input  logic [31:0]            cfg_wdata,
  output cs_cfg_t [NUM_CS-1:0]   cfg_o
);

  logic [NUM_CS-1:0] wide_q;
  cs_cfg_t           word_q [NUM_CS];

  always_ff @(posedge clk) begin
    if (rst) wide_q <= '0;
    else if (cfg_we && cfg_sel == '0) wide_q <= cfg_wdata[NUM_CS-1:0];
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst) word_q[i] <= decode_ctrl(CTRL_RESET);
      else if (cfg_we && cfg_sel == SEL_W'(i + 1)) word_q[i] <= decode_ctrl(cfg_wdata);
    end

    always_comb begin
      cfg_o[i]       = word_q[i];
      cfg_o[i].addr4 = wide_q[i];
    end
  end

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter
  import spi_seq_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  lane_e      lanes,
  input  logic       rx_wide,
  input  logic [3:0] io_in,
  output logic       sclk,
  output logic [3:0] io_out,
  output logic [3:0] io_oe,
  output logic       done,
  output logic [7:0] rx_byte
);

  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(DIV / 2 - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(DIV - 1);

  logic            busy_q;
  logic [PH_W-1:0] ph_q;
  logic [3:0]      steps_q;
  logic [7:0]      sh_q;
  lane_e           lanes_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ph_q    <= '0;
      steps_q <= '0;
      sh_q    <= '0;
      lanes_q <= LANE_X1;
      sclk    <= 1'b0;
      io_out  <= '0;
      io_oe   <= '0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          ph_q    <= '0;
          sh_q    <= tx_byte;
          lanes_q <= lanes;
          io_out  <= {3'b000, tx_byte[7]};
          unique case (lanes)
            LANE_X2: steps_q <= 4'd4;
            LANE_X4: steps_q <= 4'd2;
            default: steps_q <= 4'd8;
          endcase
          io_oe   <= (rx_wide && lanes != LANE_X1) ? 4'b0000 : 4'b0001;
        end
      end else begin
        ph_q <= ph_q + 1'b1;
        if (ph_q == PH_RISE) begin
          sclk <= 1'b1;
          unique case (lanes_q)
            LANE_X2: rx_byte <= {rx_byte[5:0], io_in[1:0]};
            LANE_X4: rx_byte <= {rx_byte[3:0], io_in};
            default: rx_byte <= {rx_byte[6:0], io_in[1]};
          endcase
        end
        if (ph_q == PH_FALL) begin
          sclk    <= 1'b0;
          ph_q    <= '0;
          steps_q <= steps_q - 1'b1;
          if (steps_q == 4'd1) begin
            busy_q <= 1'b0;
            done   <= 1'b1;
            io_oe  <= '0;
          end else begin
            sh_q      <= {sh_q[6:0], 1'b0};
            io_out[0] <= sh_q[6];
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int WIN_AW = 32,
  parameter int DIV    = 4,
  localparam int SEL_W = $clog2(NUM_CS + 1),
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              win_req,
  input  logic              win_we,
  input  logic [CS_W-1:0]   win_cs,
  input  logic [WIN_AW-1:0] win_addr,
  input  logic [7:0]        win_wdata,
  output logic [7:0]        win_rdata,
  output logic              win_ready,
  output logic              sclk,
  output logic [NUM_CS-1:0] cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} st_e;

  cs_cfg_t [NUM_CS-1:0] cfg_all;
  cs_cfg_t              req_cfg;
  cs_cfg_t              txn_cfg;
  st_e                  state_q;
  logic [CS_W-1:0]      txn_cs_q;
  logic [3:0]           step_q, last_q, ab_q;
  logic [31:0]          addr_q;
  logic [7:0]           wdata_q;
  logic                 user_q, we_q, txn_act_q;
  logic [NUM_CS-1:0]    stop_vec;
  logic                 eng_idle;
  logic                 cs_valid;

  logic                 sh_start, sh_done, sh_rx_wide;
  logic [7:0]           sh_tx, sh_rx;
  lane_e                sh_lanes;
  logic [31:0]          addr_shift;

  spi_seq_regs #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_o(cfg_all)
  );

  spi_seq_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx),
    .lanes(sh_lanes), .rx_wide(sh_rx_wide), .io_in(io_in),
    .sclk(sclk), .io_out(io_out), .io_oe(io_oe),
    .done(sh_done), .rx_byte(sh_rx)
  );

  assign cs_valid = (int'(win_cs) < NUM_CS);
  assign req_cfg  = cfg_all[win_cs];
  assign txn_cfg  = cfg_all[txn_cs_q];
  assign eng_idle = (state_q == ST_IDLE);
  assign sh_start = (state_q == ST_LOAD);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_stop
    assign stop_vec[i] = cfg_all[i].stop;
  end

  // Byte and lane selection for the current step of a transfer
  always_comb begin
    addr_shift = addr_q >> {ab_q - step_q, 3'b000};
    sh_tx      = 8'hFF;
    sh_lanes   = LANE_X1;
    sh_rx_wide = 1'b0;
    if (user_q) begin
      if (we_q) begin
        sh_tx = wdata_q;
      end else begin
        sh_lanes   = txn_cfg.lanes;
        sh_rx_wide = 1'b1;
      end
    end else if (step_q == 4'd0) begin
      sh_tx = txn_cfg.opcode;
    end else if (step_q <= ab_q) begin
      sh_tx = addr_shift[7:0];
    end else if (step_q == last_q) begin
      sh_lanes   = txn_cfg.lanes;
      sh_rx_wide = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      txn_cs_q  <= '0;
      step_q    <= '0;
      last_q    <= '0;
      ab_q      <= 4'd3;
      addr_q    <= '0;
      wdata_q   <= '0;
      user_q    <= 1'b0;
      we_q      <= 1'b0;
      txn_act_q <= 1'b0;
      win_rdata <= '0;
      win_ready <= 1'b0;
    end else begin
      win_ready <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (win_req && !win_ready) begin
            txn_cs_q <= win_cs;
            step_q   <= '0;
            wdata_q  <= win_wdata;
            we_q     <= win_we;
            addr_q   <= 32'(win_addr);
            ab_q     <= req_cfg.addr4 ? 4'd4 : 4'd3;
            if (cs_valid && req_cfg.mode == MODE_USER) begin
              user_q  <= 1'b1;
              last_q  <= '0;
              state_q <= ST_LOAD;
            end else if (cs_valid && req_cfg.mode == MODE_READ && !win_we) begin
              user_q    <= 1'b0;
              last_q    <= 4'd1 + (req_cfg.addr4 ? 4'd4 : 4'd3) + {1'b0, req_cfg.dummy};
              txn_act_q <= 1'b1;
              state_q   <= ST_LOAD;
            end else begin
              if (!win_we) win_rdata <= '0;
              win_ready <= 1'b1;
            end
          end
        end
        ST_LOAD: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (sh_done) begin
            if (step_q == last_q) begin
              if (!(user_q && we_q)) win_rdata <= sh_rx;
              win_ready <= 1'b1;
              txn_act_q <= 1'b0;
              state_q   <= ST_IDLE;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Chip-select framing: stop bit overrides, user mode or engine transaction asserts
  for (genvar i = 0; i < NUM_CS; i++) begin : g_csn
    always_ff @(posedge clk) begin
      if (rst) cs_n[i] <= 1'b1;
      else cs_n[i] <= stop_vec[i] ||
                      !((cfg_all[i].mode == MODE_USER) ||
                        (txn_act_q && txn_cs_q == CS_W'(i)));
    end
  end

endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic [3:0]        io_oe,
  input logic              win_ready,
  input logic [NUM_CS-1:0] stop_vec,
  input logic              eng_idle
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_stop
    a_r2_stop_keeps_cs_high: assert property (@(posedge clk) disable iff (rst)
      stop_vec[i] |=> cs_n[i]);
  end

  a_r7_sclk_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    eng_idle |-> !sclk);

  a_r7_ready_one_cycle: assert property (@(posedge clk) disable iff (rst)
    win_ready |=> !win_ready);

  a_r7_no_ready_while_busy: assert property (@(posedge clk) disable iff (rst)
    !eng_idle |-> !win_ready);

  a_r6_at_most_one_output_line: assert property (@(posedge clk) disable iff (rst)
    $countones(io_oe) <= 1);

endmodule

bind spi_seq spi_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .io_oe(io_oe),
  .win_ready(win_ready), .stop_vec(stop_vec), .eng_idle(eng_idle)
);

// File: tb/spi_seq_bench.sv
module spi_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic       win_req = 1'b0, win_we = 1'b0;
  logic [0:0] win_cs = '0;
  logic [31:0] win_addr = '0;
  logic [7:0] win_wdata = '0, win_rdata;
  logic       win_ready, sclk;
  logic [1:0] cs_n;
  logic [3:0] io_out, io_oe;
  logic [3:0] io_in = '0;

  always #5 clk = ~clk;

  spi_seq u_spi_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .win_req(win_req), .win_we(win_we), .win_cs(win_cs), .win_addr(win_addr),
    .win_wdata(win_wdata), .win_rdata(win_rdata), .win_ready(win_ready),
    .sclk(sclk), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // Behavioural flash state
  int     m_ab = 3, m_dummy = 0, m_lanes = 1;
  bit     m_user = 0;
  logic [7:0] m_data = '0;
  logic [1:0] m_cs_exp = 2'b11;
  int     nr = 0, rises_total = 0;
  logic [127:0] mlog = '0;
  bit     oe_bad = 0, cs_bad = 0;
  logic   prev_sclk = 1'b0, prev_all_high = 1'b1;

  function automatic int data_start();
    return m_user ? 0 : 8 * (1 + m_ab + m_dummy);
  endfunction

  function automatic logic [3:0] flash_drive(input int n);
    int j;
    if (n < data_start()) return 4'b0000;
    j = (n - data_start()) % (8 / m_lanes);
    case (m_lanes)
      2:       return {2'b00, m_data[7 - 2*j -: 2]};
      4:       return m_data[7 - 4*j -: 4];
      default: return {2'b00, m_data[7 - j], 1'b0};
    endcase
  endfunction

  always @(negedge clk) begin
    if (prev_all_high && !(&cs_n)) nr = 0;
    if (!prev_sclk && sclk) begin
      rises_total++;
      mlog = {mlog[126:0], io_out[0]};
      if (!m_user && nr >= data_start() && m_lanes > 1 && io_oe != 4'b0000) oe_bad = 1;
      if (cs_n != m_cs_exp) cs_bad = 1;
      nr++;
    end
    io_in = flash_drive(nr);
    prev_sclk = sclk;
    prev_all_high = &cs_n;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic win_access(input logic we, input logic [0:0] cs, input logic [31:0] addr,
                            input logic [7:0] wd, output logic [7:0] rd, output int cycles);
    @(negedge clk);
    win_req = 1'b1; win_we = we; win_cs = cs; win_addr = addr; win_wdata = wd;
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
    end while (!win_ready && cycles < 20000);
    rd = win_rdata;
    win_req = 1'b0;
  endtask

  typedef struct packed {
    logic [0:0]  cs;
    logic [31:0] ctrl;
    logic        a4;
    logic [31:0] addr;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{cs: 1'b0, ctrl: 32'h0003_0001, a4: 1'b0, addr: 32'h0012_3456},
    '{cs: 1'b0, ctrl: 32'h000B_0041, a4: 1'b0, addr: 32'h0000_ABCD},
    '{cs: 1'b1, ctrl: 32'h203B_0041, a4: 1'b1, addr: 32'h0123_4567},
    '{cs: 1'b1, ctrl: 32'h406B_4041, a4: 1'b1, addr: 32'h89AB_CDEF},
    '{cs: 1'b0, ctrl: 32'h40EB_4001, a4: 1'b0, addr: 32'h00FF_FFFF}
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [7:0] rd;
    int cyc, r0;
    logic [127:0] hdr;
    logic [63:0] mask;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 cs_n", 64'(cs_n), 64'h3);
    check("R10 sclk", 64'(sclk), 64'h0);
    check("R10 io_oe", 64'(io_oe), 64'h0);
    check("R10 ready", 64'(win_ready), 64'h0);

    // Table of read-mode transactions (R1 R3 R4 R5 R6 R7)
    for (int k = 0; k < 5; k++) begin
      vec_t v;
      v = VECS[k];
      cfg_write(2'd0, v.a4 ? (32'h11 << v.cs) : 32'h0);
      cfg_write(2'(v.cs) + 2'd1, v.ctrl);
      m_user   = 0;
      m_ab     = v.a4 ? 4 : 3;
      m_dummy  = int'({v.ctrl[14], v.ctrl[7:6]});
      m_lanes  = v.ctrl[30] ? 4 : (v.ctrl[29] ? 2 : 1);
      m_data   = v.addr[7:0] ^ 8'hA5;
      m_cs_exp = ~(2'b01 << v.cs);
      oe_bad = 0; cs_bad = 0;
      r0 = rises_total;
      win_access(1'b0, v.cs, v.addr, 8'h00, rd, cyc);
      check("R1 R6 read data", 64'(rd), 64'(m_data));
      check("R7 R5 rise count", 64'(rises_total - r0), 64'(8 * (1 + m_ab + m_dummy) + 8 / m_lanes));
      hdr = mlog >> (8 / m_lanes);
      check("R3 opcode", 64'(8'(hdr >> (8 * (m_ab + m_dummy)))), 64'(v.ctrl[23:16]));
      mask = (64'h1 << (8 * m_ab)) - 64'h1;
      check("R4 address", 64'(hdr >> (8 * m_dummy)) & mask, 64'(v.addr) & mask);
      mask = (64'h1 << (8 * m_dummy)) - 64'h1;
      check("R5 dummy bytes", 64'(hdr) & mask, mask);
      check("R6 oe low in wide data", 64'(oe_bad), 64'h0);
      check("R2 cs framing", 64'(cs_bad), 64'h0);
      if (k == 0) begin
        check("R7 stall length", 64'(cyc >= 160), 64'h1);
        @(negedge clk);
        check("R7 ready single cycle", 64'(win_ready), 64'h0);
      end
    end

    // R9 write in read mode is ignored
    m_cs_exp = 2'b11; cs_bad = 0;
    r0 = rises_total;
    win_access(1'b1, 1'b0, 32'h0000_0010, 8'h5A, rd, cyc);
    check("R9 no sclk", 64'(rises_total - r0), 64'h0);
    check("R9 fast completion", 64'(cyc <= 2), 64'h1);
    check("R9 cs_n high", 64'(cs_n), 64'h3);

    // R1 normal and write modes complete at once
    cfg_write(2'd1, 32'h0000_0000);
    r0 = rises_total;
    win_access(1'b0, 1'b0, 32'h0000_0020, 8'h00, rd, cyc);
    check("R1 normal mode data", 64'(rd), 64'h0);
    check("R1 normal mode no sclk", 64'(rises_total - r0), 64'h0);
    cfg_write(2'd1, 32'h0000_0002);
    win_access(1'b0, 1'b0, 32'h0000_0030, 8'h00, rd, cyc);
    check("R1 write mode data", 64'(rd), 64'h0);
    check("R1 write mode no sclk", 64'(rises_total - r0), 64'h0);
    check("R1 write mode fast", 64'(cyc <= 2), 64'h1);

    // R2 / R8 user mode
    cfg_write(2'd1, 32'h0000_0007);
    check("R2 stop keeps cs high", 64'(cs_n), 64'h3);
    m_user = 1; m_lanes = 1; m_data = 8'hC2; m_cs_exp = 2'b10; cs_bad = 0;
    cfg_write(2'd1, 32'h0000_0003);
    check("R2 user cs low", 64'(cs_n), 64'h2);
    r0 = rises_total;
    win_access(1'b1, 1'b0, 32'h0, 8'h9F, rd, cyc);
    check("R8 write byte", 64'(mlog[7:0]), 64'h9F);
    check("R8 write rises", 64'(rises_total - r0), 64'd8);
    win_access(1'b0, 1'b0, 32'h0, 8'h00, rd, cyc);
    check("R8 single read", 64'(rd), 64'hC2);
    cfg_write(2'd1, 32'h2000_0003);
    m_lanes = 2; m_data = 8'h3C;
    r0 = rises_total;
    win_access(1'b0, 1'b0, 32'h0, 8'h00, rd, cyc);
    check("R8 R6 dual read", 64'(rd), 64'h3C);
    check("R6 dual rises", 64'(rises_total - r0), 64'd4);
    cfg_write(2'd1, 32'h4000_0003);
    m_lanes = 4; m_data = 8'hE1;
    win_access(1'b0, 1'b0, 32'h0, 8'h00, rd, cyc);
    check("R8 R6 quad read", 64'(rd), 64'hE1);
    check("R2 cs held in user", 64'(cs_bad), 64'h0);
    check("R2 cs still low", 64'(cs_n), 64'h2);
    cfg_write(2'd1, 32'h0000_0007);
    check("R2 stop releases cs", 64'(cs_n), 64'h3);

    finish_run();
  end

endmodule